// File: doc/BRIEF.md
# Coherence Miss Classifier

This block sorts the misses of a small snooping multiprocessor model into four causes: cold, capacity, true sharing and false sharing. For every pair of processor and tracked block it holds a history entry: a bit saying whether that processor has ever filled the block, a field recording what removed its last copy (nothing, replacement or invalidation), and one bit per word marking words that another processor wrote after this processor last filled the block.

A performance model or trace player drives four kinds of event into it: misses, remote word writes, invalidations and replacements. Each miss is classified from the history held before that miss, and the miss then counts as a new fill. The block presents a registered code with a one-cycle strobe and keeps one saturating counter per category. Software clears the counters with a synchronous clear input. The table is indexed directly by block number, so the block tracks only NUM_BLOCKS blocks for each of NUM_PROCS processors.

Top module: `miss_classifier`

## Requirements
- R1: A miss by a processor on a block that processor has not filled since reset is given code 0 (cold). This holds even when other processors already hold that block.
- R2: A miss is given code 1 (capacity) when the processor has filled the block before, no remote write has marked any word of its entry since that fill, and the last removal was not an invalidation.
- R3: A miss is given code 2 (true sharing) when the processor has filled the block before and the word being missed on was written by another processor since the last fill. This applies whether the copy was invalidated or replaced.
- R4: A miss is given code 3 (false sharing) when the processor has filled the block before and the missed word is unmarked, provided either the last removal was an invalidation or some other word of the entry is marked.
- R5: A write marks the written word in the entry of every processor except the writer. A processor's own writes never change how its own misses are classified.
- R6: A miss is a fill. It sets the referenced bit, clears the removal reason and clears the written-word mask. A later miss therefore sees only writes and removals that happened after this fill.
- R7: cls_valid is high for exactly one cycle, in the cycle after each cycle in which miss_valid is high. cls_code carries the code in that same cycle. cls_valid is low after any cycle without a miss.
- R8: The counter for a category (cnt_cold code 0, cnt_cap code 1, cnt_true code 2, cnt_false code 3) increases by one in the same cycle in which cls_valid presents that code. The other counters hold.
- R9: Each counter is CNT_W bits wide (16 by default) and stops at its maximum value (65535) instead of wrapping.
- R10: A high clr_counts sets all four counters to zero in the next cycle. This takes priority over an increment from a miss in the same cycle.
- R11: Reset clears every history entry and every counter, and drives cls_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_counts | input | 1 | Synchronous clear of all category counters |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_proc | input | $clog2(NUM_PROCS) | Processor taking the miss |
| miss_blk | input | $clog2(NUM_BLOCKS) | Tracked block number of the miss |
| miss_word | input | $clog2(NUM_WORDS) | Word within the block being accessed |
| wr_valid | input | 1 | A processor writes a word this cycle |
| wr_proc | input | $clog2(NUM_PROCS) | Writing processor |
| wr_blk | input | $clog2(NUM_BLOCKS) | Block written |
| wr_word | input | $clog2(NUM_WORDS) | Word written |
| inv_valid | input | 1 | A processor's copy is invalidated this cycle |
| inv_proc | input | $clog2(NUM_PROCS) | Processor losing its copy |
| inv_blk | input | $clog2(NUM_BLOCKS) | Block invalidated |
| rpl_valid | input | 1 | A processor's copy is replaced this cycle |
| rpl_proc | input | $clog2(NUM_PROCS) | Processor evicting the block |
| rpl_blk | input | $clog2(NUM_BLOCKS) | Block evicted |
| cls_valid | output | 1 | One-cycle strobe for a classification result |
| cls_code | output | 2 | 0 cold, 1 capacity, 2 true sharing, 3 false sharing |
| cnt_cold | output | CNT_W | Saturating count of cold misses |
| cnt_cap | output | CNT_W | Saturating count of capacity misses |
| cnt_true | output | CNT_W | Saturating count of true-sharing misses |
| cnt_false | output | CNT_W | Saturating count of false-sharing misses |

## Verification
Each miss, write, invalidation or replacement is driven on a falling edge and is captured by the next rising edge. The classification code, its strobe and the updated counters all come out of registers loaded on that same rising edge, so they are due one cycle after the stimulus. The bench reads all of them on the following falling edge, which also confirms that the strobe is low after non-miss events. The expected code is computed from a bench model of the history table before the model applies the fill. Counter effects, including clear and saturation, are compared at the same falling edge.

// File: rtl/mclass_pkg.sv
package mclass_pkg;

  typedef enum logic [1:0] {
    RSN_NONE = 2'd0,
    RSN_REPL = 2'd1,
    RSN_INV  = 2'd2
  } rsn_e;

  typedef enum logic [1:0] {
    CLS_COLD  = 2'd0,
    CLS_CAP   = 2'd1,
    CLS_TRUE  = 2'd2,
    CLS_FALSE = 2'd3
  } cls_e;

  localparam int NUM_CATS = 4;

endpackage

// File: rtl/mclass_table.sv
// History table: one entry per (processor, block). NUM_PROCS and NUM_BLOCKS
// must be powers of two of at least 2 so the entry index is a concatenation.
module mclass_table
  import mclass_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int NUM_WORDS  = 4,
  localparam int PW = $clog2(NUM_PROCS),
  localparam int IW = $clog2(NUM_BLOCKS),
  localparam int WW = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 miss_v,
  input  logic [PW-1:0]        miss_p,
  input  logic [IW-1:0]        miss_i,
  input  logic                 wr_v,
  input  logic [PW-1:0]        wr_p,
  input  logic [IW-1:0]        wr_i,
  input  logic [WW-1:0]        wr_w,
  input  logic                 inv_v,
  input  logic [PW-1:0]        inv_p,
  input  logic [IW-1:0]        inv_i,
  input  logic                 rpl_v,
  input  logic [PW-1:0]        rpl_p,
  input  logic [IW-1:0]        rpl_i,
  output logic                 rd_ref,
  output rsn_e                 rd_rsn,
  output logic [NUM_WORDS-1:0] rd_msk
);

  localparam int NE = NUM_PROCS * NUM_BLOCKS;
  localparam int EW = PW + IW;

  logic [NE-1:0]           ref_vec;
  logic [2*NE-1:0]         rsn_vec;
  logic [NUM_WORDS*NE-1:0] msk_vec;
  logic [NUM_WORDS-1:0]    wr_bit;
  logic [EW-1:0]           rd_e;

  assign wr_bit = NUM_WORDS'(1) << wr_w;

  for (genvar p = 0; p < NUM_PROCS; p++) begin : g_proc
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
      localparam int E = p * NUM_BLOCKS + b;
      logic                 ref_q;
      logic [1:0]           rsn_q;
      logic [NUM_WORDS-1:0] msk_q;
      logic                 hit_miss, hit_wr, hit_inv, hit_rpl;

      assign hit_miss = miss_v && (miss_p == PW'(p)) && (miss_i == IW'(b));
      assign hit_wr   = wr_v   && (wr_p  != PW'(p)) && (wr_i  == IW'(b));
      assign hit_inv  = inv_v  && (inv_p == PW'(p)) && (inv_i == IW'(b));
      assign hit_rpl  = rpl_v  && (rpl_p == PW'(p)) && (rpl_i == IW'(b));

      always_ff @(posedge clk) begin
        if (rst) begin
          ref_q <= 1'b0;
          rsn_q <= RSN_NONE;
          msk_q <= '0;
        end else begin
          if (hit_miss) ref_q <= 1'b1;
          if (hit_miss)     rsn_q <= RSN_NONE;
          else if (hit_inv) rsn_q <= RSN_INV;
          else if (hit_rpl) rsn_q <= RSN_REPL;
          msk_q <= (hit_miss ? '0 : msk_q) | (hit_wr ? wr_bit : '0);
        end
      end

      assign ref_vec[E]                        = ref_q;
      assign rsn_vec[2*E +: 2]                 = rsn_q;
      assign msk_vec[NUM_WORDS*E +: NUM_WORDS] = msk_q;
    end
  end

  assign rd_e   = {miss_p, miss_i};
  assign rd_ref = ref_vec[rd_e];
  assign rd_rsn = rsn_e'(rsn_vec[2*rd_e +: 2]);
  assign rd_msk = msk_vec[NUM_WORDS*rd_e +: NUM_WORDS];

endmodule

// File: rtl/mclass_decide.sv
module mclass_decide
  import mclass_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  localparam int WW = $clog2(NUM_WORDS)
) (
  input  logic                 ent_ref,
  input  rsn_e                 ent_rsn,
  input  logic [NUM_WORDS-1:0] ent_msk,
  input  logic [WW-1:0]        word,
  output cls_e                 code
);

  always_comb begin
    if (!ent_ref)
      code = CLS_COLD;
    else if (ent_msk[word])
      code = CLS_TRUE;
    else if ((ent_rsn == RSN_INV) || (|ent_msk))
      code = CLS_FALSE;
    else
      code = CLS_CAP;
  end

endmodule

// File: rtl/mclass_counters.sv
module mclass_counters
  import mclass_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      inc_v,
  input  cls_e                      inc_cat,
  output logic [NUM_CATS*CNT_W-1:0] cnt_flat
);

  for (genvar c = 0; c < NUM_CATS; c++) begin : g_cat
    logic [CNT_W-1:0] cnt_q;
    logic             bump;

    assign bump = inc_v && (inc_cat == cls_e'(c)) && (cnt_q != '1);

    always_ff @(posedge clk) begin
      if (rst || clr)
        cnt_q <= '0;
      else if (bump)
        cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_flat[c*CNT_W +: CNT_W] = cnt_q;
  end

endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
  import mclass_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int NUM_WORDS  = 4,
  parameter int CNT_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr_counts,
  input  logic                          miss_valid,
  input  logic [$clog2(NUM_PROCS)-1:0]  miss_proc,
  input  logic [$clog2(NUM_BLOCKS)-1:0] miss_blk,
  input  logic [$clog2(NUM_WORDS)-1:0]  miss_word,
  input  logic                          wr_valid,
  input  logic [$clog2(NUM_PROCS)-1:0]  wr_proc,
  input  logic [$clog2(NUM_BLOCKS)-1:0] wr_blk,
  input  logic [$clog2(NUM_WORDS)-1:0]  wr_word,
  input  logic                          inv_valid,
  input  logic [$clog2(NUM_PROCS)-1:0]  inv_proc,
  input  logic [$clog2(NUM_BLOCKS)-1:0] inv_blk,
  input  logic                          rpl_valid,
  input  logic [$clog2(NUM_PROCS)-1:0]  rpl_proc,
  input  logic [$clog2(NUM_BLOCKS)-1:0] rpl_blk,
  output logic                          cls_valid,
  output logic [1:0]                    cls_code,
  output logic [CNT_W-1:0]              cnt_cold,
  output logic [CNT_W-1:0]              cnt_cap,
  output logic [CNT_W-1:0]              cnt_true,
  output logic [CNT_W-1:0]              cnt_false
);

  logic                      ent_ref;
  rsn_e                      ent_rsn;
  logic [NUM_WORDS-1:0]      ent_msk;
  cls_e                      next_code;
  logic [NUM_CATS*CNT_W-1:0] cnt_flat;

  mclass_table #(
    .NUM_PROCS (NUM_PROCS),
    .NUM_BLOCKS(NUM_BLOCKS),
    .NUM_WORDS (NUM_WORDS)
  ) u_table (
    .clk   (clk),
    .rst   (rst),
    .miss_v(miss_valid),
    .miss_p(miss_proc),
    .miss_i(miss_blk),
    .wr_v  (wr_valid),
    .wr_p  (wr_proc),
    .wr_i  (wr_blk),
    .wr_w  (wr_word),
    .inv_v (inv_valid),
    .inv_p (inv_proc),
    .inv_i (inv_blk),
    .rpl_v (rpl_valid),
    .rpl_p (rpl_proc),
    .rpl_i (rpl_blk),
    .rd_ref(ent_ref),
    .rd_rsn(ent_rsn),
    .rd_msk(ent_msk)
  );

  mclass_decide #(
    .NUM_WORDS(NUM_WORDS)
  ) u_decide (
    .ent_ref(ent_ref),
    .ent_rsn(ent_rsn),
    .ent_msk(ent_msk),
    .word   (miss_word),
    .code   (next_code)
  );

  mclass_counters #(
    .CNT_W(CNT_W)
  ) u_counters (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_counts),
    .inc_v   (miss_valid),
    .inc_cat (next_code),
    .cnt_flat(cnt_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_valid <= 1'b0;
      cls_code  <= CLS_COLD;
    end else begin
      cls_valid <= miss_valid;
      if (miss_valid) cls_code <= next_code;
    end
  end

  assign cnt_cold  = cnt_flat[0*CNT_W +: CNT_W];
  assign cnt_cap   = cnt_flat[1*CNT_W +: CNT_W];
  assign cnt_true  = cnt_flat[2*CNT_W +: CNT_W];
  assign cnt_false = cnt_flat[3*CNT_W +: CNT_W];

endmodule

// File: rtl/mclass_checker.sv
module mclass_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_counts,
  input logic             miss_valid,
  input logic             cls_valid,
  input logic [1:0]       cls_code,
  input logic [CNT_W-1:0] cnt_cold,
  input logic [CNT_W-1:0] cnt_cap,
  input logic [CNT_W-1:0] cnt_true,
  input logic [CNT_W-1:0] cnt_false
);

  a_r7_strobe_after_miss: assert property (@(posedge clk) disable iff (rst)
    miss_valid |=> cls_valid);

  a_r7_no_spurious_strobe: assert property (@(posedge clk) disable iff (rst)
    !miss_valid |=> !cls_valid);

  a_r8_false_step: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !clr_counts && cnt_false != '1) |=>
      (cls_code != 2'd3 || cnt_false == $past(cnt_false) + 1'b1));

  a_r8_cold_step: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !clr_counts && cnt_cold != '1) |=>
      (cls_code != 2'd0 || cnt_cold == $past(cnt_cold) + 1'b1));

  a_r8_true_monotonic: assert property (@(posedge clk) disable iff (rst)
    !clr_counts |=> cnt_true >= $past(cnt_true));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cnt_cap == '1 && !clr_counts) |=> cnt_cap == '1);

  a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr_counts |=> (cnt_cold == '0 && cnt_cap == '0 &&
                    cnt_true == '0 && cnt_false == '0));

endmodule

bind miss_classifier mclass_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/miss_classifier_test.sv
`timescale 1ns/1ps
module miss_classifier_test;

  localparam int NP = 4;
  localparam int NB = 8;
  localparam int NW = 4;
  localparam int CW = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_counts = 1'b0;
  logic miss_valid = 1'b0, wr_valid = 1'b0, inv_valid = 1'b0, rpl_valid = 1'b0;
  logic [1:0] miss_proc = '0, wr_proc = '0, inv_proc = '0, rpl_proc = '0;
  logic [2:0] miss_blk = '0, wr_blk = '0, inv_blk = '0, rpl_blk = '0;
  logic [1:0] miss_word = '0, wr_word = '0;
  logic cls_valid;
  logic [1:0] cls_code;
  logic [CW-1:0] cnt_cold, cnt_cap, cnt_true, cnt_false;

  always #5 clk = ~clk;

  miss_classifier #(.NUM_PROCS(NP), .NUM_BLOCKS(NB), .NUM_WORDS(NW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .clr_counts(clr_counts),
    .miss_valid(miss_valid), .miss_proc(miss_proc), .miss_blk(miss_blk), .miss_word(miss_word),
    .wr_valid(wr_valid), .wr_proc(wr_proc), .wr_blk(wr_blk), .wr_word(wr_word),
    .inv_valid(inv_valid), .inv_proc(inv_proc), .inv_blk(inv_blk),
    .rpl_valid(rpl_valid), .rpl_proc(rpl_proc), .rpl_blk(rpl_blk),
    .cls_valid(cls_valid), .cls_code(cls_code),
    .cnt_cold(cnt_cold), .cnt_cap(cnt_cap), .cnt_true(cnt_true), .cnt_false(cnt_false)
  );

  int n_checks = 0;
  int n_fail = 0;

  // bench model: reason 0 none, 1 replaced, 2 invalidated
  bit       m_ref [NP][NB];
  int       m_rsn [NP][NB];
  bit [3:0] m_msk [NP][NB];
  int       m_cnt [4];

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(int p, int b, int w);
    if (!m_ref[p][b]) return 0;
    if (m_msk[p][b][w]) return 2;
    if (m_rsn[p][b] == 2 || m_msk[p][b] != 0) return 3;
    return 1;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < NB; b++) begin
        m_ref[p][b] = 0; m_rsn[p][b] = 0; m_msk[p][b] = '0;
      end
    for (int c = 0; c < 4; c++) m_cnt[c] = 0;
  endtask

  task automatic idle_inputs();
    miss_valid = 0; wr_valid = 0; inv_valid = 0; rpl_valid = 0; clr_counts = 0;
  endtask

  task automatic check_counts(string req);
    chk(cnt_cold  == CW'(m_cnt[0]), {req, " cnt_cold"},  int'(cnt_cold),  m_cnt[0]);
    chk(cnt_cap   == CW'(m_cnt[1]), {req, " cnt_cap"},   int'(cnt_cap),   m_cnt[1]);
    chk(cnt_true  == CW'(m_cnt[2]), {req, " cnt_true"},  int'(cnt_true),  m_cnt[2]);
    chk(cnt_false == CW'(m_cnt[3]), {req, " cnt_false"}, int'(cnt_false), m_cnt[3]);
  endtask

  // all tasks start and end on a falling edge
  task automatic ev_miss(int p, int b, int w, bit clr, string req);
    int e;
    e = exp_code(p, b, w);
    miss_valid = 1; miss_proc = 2'(p); miss_blk = 3'(b); miss_word = 2'(w);
    clr_counts = clr;
    m_ref[p][b] = 1; m_rsn[p][b] = 0; m_msk[p][b] = '0;
    if (clr) for (int c = 0; c < 4; c++) m_cnt[c] = 0;
    else if (m_cnt[e] < CMAX) m_cnt[e]++;
    @(negedge clk);
    idle_inputs();
    chk(cls_valid == 1'b1, {req, " R7 strobe"}, int'(cls_valid), 1);
    chk(int'(cls_code) == e, {req, " code"}, int'(cls_code), e);
    check_counts({req, " R8"});
  endtask

  task automatic ev_wr(int p, int b, int w);
    wr_valid = 1; wr_proc = 2'(p); wr_blk = 3'(b); wr_word = 2'(w);
    for (int q = 0; q < NP; q++) if (q != p) m_msk[q][b][w] = 1'b1;
    @(negedge clk);
    idle_inputs();
    chk(cls_valid == 1'b0, "R7 no strobe after write", int'(cls_valid), 0);
  endtask

  task automatic ev_inv(int p, int b);
    inv_valid = 1; inv_proc = 2'(p); inv_blk = 3'(b);
    m_rsn[p][b] = 2;
    @(negedge clk);
    idle_inputs();
    chk(cls_valid == 1'b0, "R7 no strobe after invalidate", int'(cls_valid), 0);
  endtask

  task automatic ev_rpl(int p, int b);
    rpl_valid = 1; rpl_proc = 2'(p); rpl_blk = 3'(b);
    m_rsn[p][b] = 1;
    @(negedge clk);
    idle_inputs();
    chk(cls_valid == 1'b0, "R7 no strobe after replace", int'(cls_valid), 0);
  endtask

  task automatic ev_clear();
    clr_counts = 1;
    for (int c = 0; c < 4; c++) m_cnt[c] = 0;
    @(negedge clk);
    idle_inputs();
    check_counts("R10 clear");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int r, p, b, w;
    void'($urandom(32'h5eed_1234));
    model_reset();
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cls_valid == 1'b0, "R11 reset strobe", int'(cls_valid), 0);
    check_counts("R11 reset");

    // R1 cold, per processor
    ev_miss(0, 1, 0, 0, "R1 first fill p0");
    ev_miss(1, 1, 0, 0, "R1 first fill p1 same block");
    // R2 capacity after replacement with no remote writes
    ev_rpl(0, 1);
    ev_miss(0, 1, 2, 0, "R2 replaced, untouched");
    // R3 true sharing after invalidation
    ev_inv(0, 1);
    ev_wr(1, 1, 3);
    ev_miss(0, 1, 3, 0, "R3 invalidated, same word written");
    // R4 false sharing after invalidation
    ev_inv(0, 1);
    ev_wr(1, 1, 2);
    ev_miss(0, 1, 0, 0, "R4 invalidated, other word written");
    // R4 invalidated with no write recorded
    ev_inv(0, 1);
    ev_miss(0, 1, 1, 0, "R4 invalidated, no marks");
    // R3 replaced then modified
    ev_rpl(1, 1);
    ev_wr(2, 1, 0);
    ev_miss(1, 1, 0, 0, "R3 replaced then same word written");
    // R6 fill cleared old mark, R4 replaced path
    ev_rpl(1, 1);
    ev_wr(2, 1, 1);
    ev_miss(1, 1, 0, 0, "R6 R4 replaced, only other word since fill");
    // R5 own write has no effect
    ev_miss(2, 3, 0, 0, "R1 cold p2");
    ev_rpl(2, 3);
    ev_wr(2, 3, 0);
    ev_miss(2, 3, 0, 0, "R5 own write ignored");
    // R10 clear and clear-with-miss priority
    ev_clear();
    ev_miss(3, 5, 1, 1, "R10 clear wins over increment");
    ev_miss(3, 5, 1, 0, "R8 count after clear");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      r = int'($urandom_range(0, 9));
      p = int'($urandom_range(0, NP - 1));
      b = int'($urandom_range(0, NB - 1));
      w = int'($urandom_range(0, NW - 1));
      if (r < 4)      ev_miss(p, b, w, 0, "R1 R2 R3 R4 random miss");
      else if (r < 7) ev_wr(p, b, w);
      else if (r < 8) ev_inv(p, b);
      else if (r < 9) ev_rpl(p, b);
      else if (i % 97 == 0) ev_clear();
      else ev_miss(p, b, w, 0, "R6 random refill");
    end

    // R9 saturation on the capacity counter
    ev_clear();
    ev_miss(0, 6, 0, 0, "R9 setup");
    for (int i = 0; i < CMAX + 4; i++)
      ev_miss(0, 6, 1, 0, "R9 saturating run");
    chk(cnt_cap == CW'(CMAX), "R9 capacity held at max", int'(cnt_cap), CMAX);

    finish_run();
  end

endmodule